// File: doc/BRIEF.md
# Configurable-sense interrupt controller

This block collects up to 32 external interrupt requests and turns each into its own interrupt line towards a parent controller. Every channel has a 6-bit sense code that chooses one of five ways of detecting a request: active-low level, active-high level, falling edge, rising edge or either edge. Each input first passes through a two-flop synchroniser. Edges are found by comparing the synchronised level with the previous sample, so detection runs in the controller clock domain.

Detections are held in a detect-status register. Software clears a bit by writing 1 to it. A channel's output line is high while its detect bit and its enable bit are both set. Enables are changed through two write-only strobes: one address sets the bits written as 1, and another clears them.

Each channel's detect bit is a two-state machine. The states are `CH_IDLE` (nothing latched) and `CH_PENDING` (detection latched). The transitions are:
- `T_HIT`: `CH_IDLE` to `CH_PENDING`, taken when the selected sense condition is seen.
- `T_ACK`: `CH_PENDING` to `CH_IDLE`, taken on a write-1-to-clear when there is no hit in the same cycle.
- `T_HOLD`: every other case keeps the current state.

A simple register bus gives access to the block. It has a byte address, 32-bit write data, a write strobe and combinational read data.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, all enables, all detect bits and all configuration words are zero, and every irq_out line is low.
- R2: Writing to offset 0x08 sets each enable bit written as 1. Reading offset 0x04 or offset 0x08 returns the enable mask. Bit n belongs to channel n.
- R3: Writing to offset 0x04 clears each enable bit written as 1 and leaves the other enable bits unchanged.
- R4: The configuration word of channel n is at offset 0x180 + 4*n. All 32 bits are stored and read back unchanged. Bits [5:0] hold the sense code.
- R5: A sense code other than 0x01, 0x02, 0x04, 0x08 or 0x0C detects nothing. This includes 0x00, 0x03 and 0x10.
- R6: Sense code 0x08 detects a rising edge. The detect bit reads 1 after the third rising clock edge that follows the input change, and 0 after the first and second.
- R7: Sense code 0x04 detects a falling edge. A rising edge on the input does not set the detect bit.
- R8: Sense code 0x0C detects both rising and falling edges. A steady input does not set the detect bit.
- R9: Sense code 0x02 detects a high level and sense code 0x01 detects a low level. While the level is active, a clear write does not clear the detect bit. After the level goes inactive, the bit stays set until it is cleared.
- R10: Offset 0x100 reads the detect bits. Writing to it clears each bit written as 1 and leaves the other bits unchanged.
- R11: If a detection and a clear write hit the same bit in the same cycle, the bit stays set.
- R12: irq_out[n] is high exactly when channel n's detect bit and enable bit are both 1. It follows enable and clear writes by one clock edge.
- R13: Offset 0x00 reads the synchronised input levels. A change on req_in shows up there after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | NCH | External interrupt request inputs |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_out | output | NCH | Per-channel interrupt lines to the parent controller |

## Verification
A channel machine stuck in `CH_PENDING` or `CH_IDLE` shows at the ports in two ways. It shows in the detect register read at offset 0x100 one cycle after the missed `T_HIT` or `T_ACK`. It also shows on irq_out once the channel is enabled. A wrong synchroniser depth or a wrong edge comparison moves the detect bit off its third-edge slot, so the bench samples every cycle across that window. A bad enable or configuration register shows on the very next read-back, or as a missing or extra irq_out pulse.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int SENSE_W = 6;
    localparam int DATA_W  = 32;

    // Register byte offsets
    localparam int OFS_RAW    = 'h000;
    localparam int OFS_EN_CLR = 'h004;
    localparam int OFS_EN_SET = 'h008;
    localparam int OFS_DET    = 'h100;
    localparam int OFS_CFG    = 'h180;

    typedef enum logic [2:0] {
        SENSE_NONE,
        SENSE_LVL_LO,
        SENSE_LVL_HI,
        SENSE_FALL,
        SENSE_RISE,
        SENSE_BOTH
    } sense_mode_e;

    typedef enum logic {
        CH_IDLE,
        CH_PENDING
    } det_state_e;

    function automatic sense_mode_e sense_decode(input logic [SENSE_W-1:0] code);
        sense_mode_e m;
        case (code)
            6'h01:   m = SENSE_LVL_LO;
            6'h02:   m = SENSE_LVL_HI;
            6'h04:   m = SENSE_FALL;
            6'h08:   m = SENSE_RISE;
            6'h0C:   m = SENSE_BOTH;
            default: m = SENSE_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl      = sync_q;
    assign lvl_prev = prev_q;

endmodule

// File: rtl/xirq_channel.sv
module xirq_channel
    import xirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lvl,
    input  logic               lvl_prev,
    input  logic [SENSE_W-1:0] sense,
    input  logic               clr,
    output logic               det
);

    sense_mode_e mode;
    det_state_e  state_q;
    det_state_e  state_d;
    logic        hit;

    assign mode = sense_decode(sense);

    // Sense condition for the selected mode
    always_comb begin
        unique case (mode)
            SENSE_LVL_LO: hit = ~lvl;
            SENSE_LVL_HI: hit = lvl;
            SENSE_FALL:   hit = lvl_prev & ~lvl;
            SENSE_RISE:   hit = ~lvl_prev & lvl;
            SENSE_BOTH:   hit = lvl_prev ^ lvl;
            default:      hit = 1'b0;
        endcase
    end

    // Next-state logic: T_HIT, T_ACK, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:    if (hit) state_d = CH_PENDING;
            CH_PENDING: if (clr && !hit) state_d = CH_IDLE;
            default:    state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        det = (state_q == CH_PENDING);
    end

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int NCH = 32,
    parameter int AW  = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [AW-1:0]                 addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          we,
    input  logic [NCH-1:0]                raw,
    input  logic [NCH-1:0]                det,
    output logic [NCH-1:0]                en_mask,
    output logic [NCH-1:0][SENSE_W-1:0]   sense,
    output logic [NCH-1:0]                det_clr,
    output logic [DATA_W-1:0]             rdata
);

    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int SEL_W = AW - 2;

    logic [NCH-1:0]    en_q;
    logic [NCH-1:0]    en_set;
    logic [NCH-1:0]    en_clr;
    logic              wr_en_set;
    logic              wr_en_clr;
    logic              wr_det;
    logic [AW-1:0]     cfg_off;
    logic [SEL_W-1:0]  cfg_sel;
    logic              cfg_hit;
    logic [DATA_W-1:0] cfg_q [NCH];

    assign wr_en_set = we && (addr == AW'(OFS_EN_SET));
    assign wr_en_clr = we && (addr == AW'(OFS_EN_CLR));
    assign wr_det    = we && (addr == AW'(OFS_DET));

    assign cfg_off = addr - AW'(OFS_CFG);
    assign cfg_sel = cfg_off[AW-1:2];
    assign cfg_hit = (addr >= AW'(OFS_CFG)) && (cfg_sel < SEL_W'(NCH)) &&
                     (addr[1:0] == 2'b00);

    assign en_set  = wr_en_set ? wdata[NCH-1:0] : '0;
    assign en_clr  = wr_en_clr ? wdata[NCH-1:0] : '0;
    assign det_clr = wr_det    ? wdata[NCH-1:0] : '0;

    // Simultaneous set and clear of one bit resolves as disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | en_set) & ~en_clr;
    end

    assign en_mask = en_q;

    for (genvar i = 0; i < NCH; i++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (we && cfg_hit && (cfg_sel == SEL_W'(i))) begin
                cfg_q[i] <= wdata;
            end
        end
        assign sense[i] = cfg_q[i][SENSE_W-1:0];
    end

    always_comb begin
        rdata = '0;
        if (cfg_hit) begin
            rdata = cfg_q[cfg_sel[IDX_W-1:0]];
        end else begin
            unique case (addr)
                AW'(OFS_RAW):    rdata = DATA_W'(raw);
                AW'(OFS_EN_CLR): rdata = DATA_W'(en_q);
                AW'(OFS_EN_SET): rdata = DATA_W'(en_q);
                AW'(OFS_DET):    rdata = DATA_W'(det);
                default:         rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int NCH = 32,
    parameter int AW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req_in,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq_out
);

    logic [NCH-1:0]              sync_lvl;
    logic [NCH-1:0]              sync_prev;
    logic [NCH-1:0]              en_mask;
    logic [NCH-1:0]              det_vec;
    logic [NCH-1:0]              det_clr;
    logic [NCH-1:0][SENSE_W-1:0] cfg_sense;

    xirq_sync #(.W(NCH)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (req_in),
        .lvl      (sync_lvl),
        .lvl_prev (sync_prev)
    );

    xirq_regs #(.NCH(NCH), .AW(AW)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .we      (bus_we),
        .raw     (sync_lvl),
        .det     (det_vec),
        .en_mask (en_mask),
        .sense   (cfg_sense),
        .det_clr (det_clr),
        .rdata   (bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        xirq_channel ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (sync_lvl[i]),
            .lvl_prev (sync_prev[i]),
            .sense    (cfg_sense[i]),
            .clr      (det_clr[i]),
            .det      (det_vec[i])
        );
    end

    assign irq_out = det_vec & en_mask;

endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
    import xirq_pkg::*;
#(
    parameter int NCH = 32,
    parameter int AW  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [AW-1:0]      bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               bus_we,
    input logic [NCH-1:0]     irq_out,
    input logic [NCH-1:0]     en_mask,
    input logic [NCH-1:0]     det_vec,
    input logic [SENSE_W-1:0] sense0
);

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_EN_SET)) |=>
        ((en_mask & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_EN_CLR)) |=>
        ((en_mask & $past(bus_wdata[NCH-1:0])) == '0));

    // R10
    det_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == AW'(OFS_DET)) |=>
        ((det_vec & $past(det_vec)) == $past(det_vec)));

    // R5
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_decode(sense0) == SENSE_NONE) |=> !$rose(det_vec[0]));

    // R12
    irq_needs_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~det_vec) == '0));

endmodule

bind xirq_ctrl xirq_ctrl_chk #(.NCH(NCH), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .irq_out   (irq_out),
    .en_mask   (en_mask),
    .det_vec   (det_vec),
    .sense0    (cfg_sense[0])
);

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;
    localparam int AW  = 12;
    localparam logic [AW-1:0] A_RAW = 12'h000;
    localparam logic [AW-1:0] A_ENC = 12'h004;
    localparam logic [AW-1:0] A_ENS = 12'h008;
    localparam logic [AW-1:0] A_DET = 12'h100;
    localparam int CFG0 = 'h180;
    localparam int NVEC = 14;
    // {sense[7:0], start level, end level, expected detect}
    localparam logic [10:0] VEC [NVEC] = '{
        {8'h08, 1'b0, 1'b1, 1'b1},
        {8'h08, 1'b1, 1'b0, 1'b0},
        {8'h04, 1'b1, 1'b0, 1'b1},
        {8'h04, 1'b0, 1'b1, 1'b0},
        {8'h0C, 1'b0, 1'b1, 1'b1},
        {8'h0C, 1'b1, 1'b0, 1'b1},
        {8'h0C, 1'b1, 1'b1, 1'b0},
        {8'h02, 1'b0, 1'b1, 1'b1},
        {8'h02, 1'b0, 1'b0, 1'b0},
        {8'h01, 1'b1, 1'b1, 1'b0},
        {8'h01, 1'b1, 1'b0, 1'b1},
        {8'h03, 1'b0, 1'b1, 1'b0},
        {8'h00, 1'b1, 1'b0, 1'b0},
        {8'h10, 1'b0, 1'b1, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  req_in = '0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  irq_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xirq_ctrl #(.NCH(NCH), .AW(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_in),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [AW-1:0] cfg_addr(input int n);
        return AW'(CFG0 + 4 * n);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(A_ENS, rd);          check("R1 enables", rd, 32'h0);
        peek(A_DET, rd);          check("R1 detect", rd, 32'h0);
        peek(cfg_addr(31), rd);   check("R1 config", rd, 32'h0);
        check("R1 irq_out", irq_out, 32'h0);

        // Table walk: R5 R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            req_in[v] = VEC[v][2];
            wr(cfg_addr(v), {24'h0, VEC[v][10:3]});
            repeat (4) @(negedge clk);
            wr(A_DET, 32'h1 << v);
            req_in[v] = VEC[v][1];
            repeat (4) @(negedge clk);
            peek(A_DET, rd);
            check($sformatf("R5-R9 vector %0d sense %h", v, VEC[v][10:3]),
                  {31'h0, rd[v]}, {31'h0, VEC[v][0]});
            wr(cfg_addr(v), 32'h0);
            req_in[v] = 1'b0;
            repeat (3) @(negedge clk);
            wr(A_DET, 32'h1 << v);
        end

        // R2 / R3 enable set and clear
        wr(A_ENS, 32'hF0F0_000F);
        peek(A_ENS, rd);  check("R2 set read 0x08", rd, 32'hF0F0_000F);
        peek(A_ENC, rd);  check("R2 set read 0x04", rd, 32'hF0F0_000F);
        wr(A_ENC, 32'h0000_0005);
        peek(A_ENS, rd);  check("R3 clear", rd, 32'hF0F0_000A);
        wr(A_ENC, 32'hFFFF_FFFF);
        peek(A_ENS, rd);  check("R3 clear all", rd, 32'h0);

        // R4 configuration storage
        wr(cfg_addr(5), 32'hABCD_EF08);
        peek(cfg_addr(5), rd); check("R4 readback", rd, 32'hABCD_EF08);
        peek(cfg_addr(6), rd); check("R4 neighbour", rd, 32'h0);
        wr(cfg_addr(5), 32'h0);

        // R12 output gating, channel 20 rising
        wr(cfg_addr(20), 32'h08);
        req_in[20] = 1'b1;
        repeat (4) @(negedge clk);
        peek(A_DET, rd);  check("R12 det latched", {31'h0, rd[20]}, 32'h1);
        check("R12 disabled low", {31'h0, irq_out[20]}, 32'h0);
        wr(A_ENS, 32'h1 << 20);
        check("R12 enabled high", {31'h0, irq_out[20]}, 32'h1);
        wr(A_ENC, 32'h1 << 20);
        check("R12 disabled again", {31'h0, irq_out[20]}, 32'h0);
        wr(A_ENS, 32'h1 << 20);
        wr(A_DET, 32'h1 << 20);
        check("R12 cleared low", {31'h0, irq_out[20]}, 32'h0);

        // R6 / R13 latency, channel 21 rising
        wr(cfg_addr(21), 32'h08);
        @(negedge clk);
        req_in[21] = 1'b1;
        @(negedge clk);
        peek(A_RAW, rd);  check("R13 raw after 1 edge", {31'h0, rd[21]}, 32'h0);
        peek(A_DET, rd);  check("R6 det after 1 edge", {31'h0, rd[21]}, 32'h0);
        @(negedge clk);
        peek(A_RAW, rd);  check("R13 raw after 2 edges", {31'h0, rd[21]}, 32'h1);
        peek(A_DET, rd);  check("R6 det after 2 edges", {31'h0, rd[21]}, 32'h0);
        @(negedge clk);
        peek(A_DET, rd);  check("R6 det after 3 edges", {31'h0, rd[21]}, 32'h1);

        // R11 edge and clear in the same cycle, channel 23 rising
        wr(cfg_addr(23), 32'h08);
        req_in[23] = 1'b1;
        repeat (4) @(negedge clk);
        req_in[23] = 1'b0;
        repeat (4) @(negedge clk);
        req_in[23] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr  = A_DET;
        bus_wdata = 32'h1 << 23;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        peek(A_DET, rd);  check("R11 edge beats clear", {31'h0, rd[23]}, 32'h1);

        // R10 selective clear
        wr(A_DET, 32'h1 << 23);
        peek(A_DET, rd);
        check("R10 selective clear", rd & 32'h00A0_0000, 32'h0020_0000);

        // R9 level high cannot be cleared while active, channel 24
        wr(cfg_addr(24), 32'h02);
        req_in[24] = 1'b1;
        repeat (4) @(negedge clk);
        wr(A_DET, 32'h1 << 24);
        peek(A_DET, rd);  check("R9 clear while active", {31'h0, rd[24]}, 32'h1);
        req_in[24] = 1'b0;
        repeat (4) @(negedge clk);
        peek(A_DET, rd);  check("R9 latched after inactive", {31'h0, rd[24]}, 32'h1);
        wr(A_DET, 32'h1 << 24);
        peek(A_DET, rd);  check("R9 cleared when inactive", {31'h0, rd[24]}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule